// File: doc/BRIEF.md
# Strobe-Framed Serial PCM Port

This block is a serial voice-data port with two 8-bit B-channel slots. A remote device supplies a bit clock and two enable strobes. Each strobe is high for one 8-bit slot and marks where that channel's byte sits in the serial stream. Received bits are sampled on the falling bit-clock edge and assembled MSB first into a parallel byte per channel. Outgoing bytes are serialized MSB first, with each bit launched on a rising bit-clock edge. The serial output is driven only inside an active slot, and outside a slot it sits at a defined low level.

The bit clock, strobes and serial input arrive asynchronously. They pass through a synchronizer into the system clock domain, where an edge detector turns bit-clock transitions into single-cycle events. Each channel has its own slot state machine with these states:

- SLOT_IDLE: the strobe is low.
- SLOT_SHIFT: bits are being taken.
- SLOT_DONE: a one-cycle delivery state.
- SLOT_FULL: 8 bits have been taken and the port waits for the strobe to drop.
- SLOT_OVER: the strobe stayed high too long.

The state machine moves between these states as follows:

- SLOT_IDLE goes to SLOT_SHIFT on a sampled strobe-high bit.
- SLOT_SHIFT stays in SLOT_SHIFT for each further bit. It goes to SLOT_DONE on the eighth bit. It goes to SLOT_IDLE with a length error if the strobe drops early.
- SLOT_DONE always goes to SLOT_FULL on the next cycle.
- SLOT_FULL goes to SLOT_IDLE when the strobe is sampled low. It goes to SLOT_OVER with a length error when the strobe is still high.
- SLOT_OVER goes to SLOT_IDLE once the strobe is sampled low.

Channel B1 stays inactive until one full-length B2 slot has been seen since reset. A low-rate mode keeps only one slot in use, and the select input chooses which one.

Top module: `pcm_strobe_port`

## Requirements
- R1: After reset, `sdo_oe`, `sdo`, both valid outputs and `strobe_err` are 0, and both received bytes read 0.
- R2: The bit on `sdi` at each falling `bclk` edge inside a strobe is captured. The first bit is the MSB. The byte appears on `rx_bN_data` together with a one-system-cycle `rx_bN_vld` pulse, one cycle after the eighth bit is stored. At most one valid output is high in any cycle.
- R3: Inside an active slot, `sdo_oe` is 1 and `sdo` carries the `tx_bN` byte MSB first, one new bit per rising `bclk` edge. The first bit appears when the strobe rises. Outside active slots, `sdo_oe` is 0 and `sdo` is 0.
- R4: A strobe that falls after fewer than 8 sampled bits sets `strobe_err`. That partial byte produces no valid pulse and leaves `rx_bN_data` unchanged.
- R5: A strobe still high at the ninth falling edge sets `strobe_err`. The first 8 bits are still delivered. Bits past the eighth drive `sdo` as 0.
- R6: Until a B2 slot reaches its eighth bit after reset, the B1 slot neither captures nor drives `sdo`.
- R7: With `low_rate`=1 and `sel`=1, only the B2 slot is used. B1 slots are neither captured nor driven.
- R8: With `low_rate`=1 and `sel`=0, only the B1 slot is used. B2 slots are neither captured nor driven, but they still enable B1 as in R6.
- R9: The port works at any bit clock from 128 kHz to 4096 kHz while `clk` runs at least 12 times faster than `bclk`.
- R10: `strobe_err` stays 1 until reset, whatever traffic follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock, asynchronous |
| sdi | input | 1 | Serial receive data |
| en_b1 | input | 1 | Slot strobe for channel B1 |
| en_b2 | input | 1 | Slot strobe for channel B2 |
| low_rate | input | 1 | 1 selects single-slot low-rate mode |
| sel | input | 1 | Low-rate slot choice: 1 selects B2, 0 selects B1 |
| tx_b1 | input | SLOT_BITS | Byte to send in the B1 slot |
| tx_b2 | input | SLOT_BITS | Byte to send in the B2 slot |
| sdo | output | 1 | Serial transmit data, 0 when idle |
| sdo_oe | output | 1 | Output enable for `sdo` |
| rx_b1_data | output | SLOT_BITS | Last byte received in B1 |
| rx_b1_vld | output | 1 | One-cycle pulse for a new B1 byte |
| rx_b2_data | output | SLOT_BITS | Last byte received in B2 |
| rx_b2_vld | output | 1 | One-cycle pulse for a new B2 byte |
| strobe_err | output | 1 | Sticky slot-length error |

## Verification
A `bclk` edge reaches the internal event after two synchronizer stages. The registers then update at the third system clock edge after the pin changes:

- On a rising edge, the new `sdo` bit is stable within about three system cycles.
- On a falling edge, the byte is stored at the third edge and the valid pulse fills the following cycle.

The bench changes strobes and data with the rising `bclk` edge. It samples `sdo` and `sdo_oe` 10 ns before the falling edge, well after the due time even at the fastest rate. Expected bytes are queued before each slot starts. A monitor on every falling system clock edge catches each valid pulse, including ones that should never occur. Error and hold checks are made two idle bit periods after a slot ends.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [2:0] {
        SLOT_IDLE,
        SLOT_SHIFT,
        SLOT_DONE,
        SLOT_FULL,
        SLOT_OVER
    } slot_state_t;

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx
    import pcm_port_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fall_ev,
    input  logic            en,
    input  logic            din,
    input  logic            load_ok,
    output logic [BITS-1:0] rx_data,
    output logic            done,
    output logic            len_err
);
    localparam int CW = $clog2(BITS + 1);

    slot_state_t   st, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [BITS-1:0] shreg;
    logic          take, last;

    always_comb begin
        take    = fall_ev && en && (st == SLOT_IDLE || st == SLOT_SHIFT);
        cnt_nxt = (st == SLOT_IDLE) ? CW'(1) : cnt + CW'(1);
        last    = (cnt_nxt == CW'(BITS));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            SLOT_IDLE:  if (take) nxt = last ? SLOT_DONE : SLOT_SHIFT;
            SLOT_SHIFT: begin
                if (take)         nxt = last ? SLOT_DONE : SLOT_SHIFT;
                else if (fall_ev) nxt = SLOT_IDLE;
            end
            SLOT_DONE:  nxt = SLOT_FULL;
            SLOT_FULL:  if (fall_ev) nxt = en ? SLOT_OVER : SLOT_IDLE;
            SLOT_OVER:  if (fall_ev && !en) nxt = SLOT_IDLE;
            default:    nxt = SLOT_IDLE;
        endcase
    end

    // bit assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            rx_data <= '0;
        end else if (take) begin
            cnt   <= cnt_nxt;
            shreg <= {shreg[BITS-2:0], din};
            if (last && load_ok) rx_data <= {shreg[BITS-2:0], din};
        end
    end

    // outputs
    always_comb begin
        done    = (st == SLOT_DONE);
        len_err = fall_ev && ((st == SLOT_SHIFT && !en) || (st == SLOT_FULL && en));
    end
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise_ev,
    input  logic            en,
    input  logic            active,
    input  logic [BITS-1:0] tx_byte,
    output logic            sdo_bit,
    output logic            drive
);
    logic [BITS-1:0] shreg;
    logic            started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            started <= 1'b0;
        end else if (!en) begin
            shreg   <= tx_byte;
            started <= 1'b0;
        end else if (rise_ev) begin
            if (started) shreg <= {shreg[BITS-2:0], 1'b0};
            started <= 1'b1;
        end
    end

    assign sdo_bit = shreg[BITS-1];
    assign drive   = en && active;
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port #(
    parameter int SLOT_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 sdi,
    input  logic                 en_b1,
    input  logic                 en_b2,
    input  logic                 low_rate,
    input  logic                 sel,
    input  logic [SLOT_BITS-1:0] tx_b1,
    input  logic [SLOT_BITS-1:0] tx_b2,
    output logic                 sdo,
    output logic                 sdo_oe,
    output logic [SLOT_BITS-1:0] rx_b1_data,
    output logic                 rx_b1_vld,
    output logic [SLOT_BITS-1:0] rx_b2_data,
    output logic                 rx_b2_vld,
    output logic                 strobe_err
);
    localparam int NUM_CH = 2;

    logic [3:0] sync_q;
    logic       bclk_s, din_s, en1_s, en2_s, bclk_d;
    logic       rise_ev, fall_ev, armed;
    logic [NUM_CH-1:0] en_v, use_v, done_v, err_v, bit_v, drv_v;
    logic [SLOT_BITS-1:0] tx_v  [NUM_CH];
    logic [SLOT_BITS-1:0] rxd_v [NUM_CH];

    pcm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({bclk, sdi, en_b1, en_b2}), .q(sync_q)
    );
    assign {bclk_s, din_s, en1_s, en2_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end
    assign rise_ev = bclk_s && !bclk_d;
    assign fall_ev = !bclk_s && bclk_d;

    assign en_v    = {en2_s, en1_s};
    assign tx_v[0] = tx_b1;
    assign tx_v[1] = tx_b2;
    assign use_v[0] = armed && (!low_rate || !sel);
    assign use_v[1] = !low_rate || sel;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pcm_slot_rx #(.BITS(SLOT_BITS)) u_rx (
            .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .en(en_v[c]), .din(din_s),
            .load_ok(use_v[c]), .rx_data(rxd_v[c]), .done(done_v[c]), .len_err(err_v[c])
        );
        pcm_slot_tx #(.BITS(SLOT_BITS)) u_tx (
            .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .en(en_v[c]), .active(use_v[c]),
            .tx_byte(tx_v[c]), .sdo_bit(bit_v[c]), .drive(drv_v[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            strobe_err <= 1'b0;
        end else begin
            if (done_v[1]) armed      <= 1'b1;
            if (|err_v)    strobe_err <= 1'b1;
        end
    end

    always_comb begin
        sdo_oe     = |drv_v;
        sdo        = drv_v[0] ? bit_v[0] : (drv_v[1] ? bit_v[1] : 1'b0);
        rx_b1_data = rxd_v[0];
        rx_b2_data = rxd_v[1];
        rx_b1_vld  = done_v[0] && use_v[0];
        rx_b2_vld  = done_v[1] && use_v[1];
    end
endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk #(
    parameter int SLOT_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sdo,
    input logic                 sdo_oe,
    input logic                 en1_s,
    input logic                 en2_s,
    input logic                 armed,
    input logic                 low_rate,
    input logic                 sel,
    input logic                 rx_b1_vld,
    input logic                 rx_b2_vld,
    input logic [SLOT_BITS-1:0] rx_b1_data,
    input logic [SLOT_BITS-1:0] rx_b2_data,
    input logic                 strobe_err
);
    AST_OE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> (en1_s || en2_s)); // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sdo_oe |-> !sdo); // R3
    AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rx_b1_vld, rx_b2_vld})); // R2
    AST_B1_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_b1_data) |-> rx_b1_vld); // R4
    AST_B2_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_b2_data) |-> rx_b2_vld); // R4
    AST_B1_ARMED: assert property (@(posedge clk) disable iff (!rst_n) rx_b1_vld |-> armed); // R6
    AST_LOW_B2_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (low_rate && sel && $past(low_rate && sel)) |-> !rx_b1_vld); // R7
    AST_LOW_B1_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (low_rate && !sel && $past(low_rate && !sel)) |-> !rx_b2_vld); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) strobe_err |=> strobe_err); // R10
endmodule

bind pcm_strobe_port pcm_strobe_port_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .en1_s(en1_s), .en2_s(en2_s),
    .armed(armed), .low_rate(low_rate), .sel(sel), .rx_b1_vld(rx_b1_vld), .rx_b2_vld(rx_b2_vld),
    .rx_b1_data(rx_b1_data), .rx_b2_data(rx_b2_data), .strobe_err(strobe_err)
);

// File: tb/pcm_strobe_port_test.sv
module pcm_strobe_port_test;
    logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, sdi = 1'b0;
    logic en_b1 = 1'b0, en_b2 = 1'b0, low_rate = 1'b0, sel = 1'b0;
    logic [7:0] tx_b1 = 8'hA5, tx_b2 = 8'h5A;
    logic sdo, sdo_oe, rx_b1_vld, rx_b2_vld, strobe_err;
    logic [7:0] rx_b1_data, rx_b2_data;

    int n_chk = 0, n_err = 0, hb = 140;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];

    pcm_strobe_port uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .sdi(sdi), .en_b1(en_b1), .en_b2(en_b2),
        .low_rate(low_rate), .sel(sel), .tx_b1(tx_b1), .tx_b2(tx_b2), .sdo(sdo), .sdo_oe(sdo_oe),
        .rx_b1_data(rx_b1_data), .rx_b1_vld(rx_b1_vld), .rx_b2_data(rx_b2_data),
        .rx_b2_vld(rx_b2_vld), .strobe_err(strobe_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en_b1 = 1'b0; en_b2 = 1'b0; bclk = 1'b0; sdi = 1'b0;
        #40; rst_n = 1'b1; #40;
    endtask

    // one bit period: inputs launched with the rising edge, output sampled before the falling edge
    task automatic bit_cycle(input logic e1, input logic e2, input logic d,
                             input logic exp_oe, input logic exp_sdo, input string req);
        bclk = 1'b1; en_b1 = e1; en_b2 = e2; sdi = d;
        #(hb - 10);
        chk(req, "sdo_oe", sdo_oe, exp_oe);
        chk(req, "sdo", sdo, exp_sdo);
        #10; bclk = 1'b0;
        #(hb);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bit_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    endtask

    // driver: queues the expected byte, then plays the slot
    task automatic slot(input int ch, input int len, input logic [7:0] rxb, input logic [7:0] txb,
                        input bit drive, input bit deliver, input string req);
        if (deliver) exp_q.push_back({ch == 2, rxb});
        for (int i = 0; i < len; i++) begin
            logic es;
            es = (drive && i < 8) ? txb[7 - i] : 1'b0;
            bit_cycle(ch == 1, ch == 2, rxb[7 - (i % 8)], drive, es, req);
        end
    endtask

    // monitor: pops the scoreboard on every valid pulse
    always @(negedge clk) begin
        logic [8:0] e;
        if (rst_n && (rx_b1_vld || rx_b2_vld)) begin
            if (exp_q.size() == 0) chk("R2", "unexpected valid", 1, 0);
            else begin
                e = exp_q.pop_front();
                chk("R2", "channel", rx_b2_vld, e[8]);
                chk("R2", "byte", rx_b2_vld ? rx_b2_data : rx_b1_data, e[7:0]);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        #5;
        do_reset();
        chk("R1", "sdo_oe", sdo_oe, 0);
        chk("R1", "sdo", sdo, 0);
        chk("R1", "valids", {rx_b1_vld, rx_b2_vld}, 0);
        chk("R1", "strobe_err", strobe_err, 0);
        chk("R1", "rx data", {rx_b1_data, rx_b2_data}, 0);

        idle(2);
        slot(1, 8, 8'h3C, tx_b1, 0, 0, "R6");        // B1 before arming
        idle(2);
        chk("R6", "b1 data before arm", rx_b1_data, 0);
        slot(2, 8, 8'hC3, tx_b2, 1, 1, "R2");
        idle(2);
        slot(1, 8, 8'h96, tx_b1, 1, 1, "R6");        // now armed
        idle(2);
        slot(2, 8, 8'h0F, tx_b2, 1, 1, "R3");
        idle(2);
        chk("R2", "no error", strobe_err, 0);

        tx_b1 = 8'h81;
        slot(1, 8, 8'hF0, tx_b1, 1, 1, "R3");
        idle(2);

        low_rate = 1'b1; sel = 1'b1;
        slot(1, 8, 8'h11, tx_b1, 0, 0, "R7");
        idle(2);
        chk("R7", "b1 data held", rx_b1_data, 8'hF0);
        slot(2, 8, 8'h22, tx_b2, 1, 1, "R7");
        idle(2);

        sel = 1'b0;
        slot(1, 8, 8'h33, tx_b1, 1, 1, "R8");
        idle(2);
        slot(2, 8, 8'h44, tx_b2, 0, 0, "R8");
        idle(2);
        chk("R8", "b2 data held", rx_b2_data, 8'h22);
        low_rate = 1'b0;

        slot(1, 5, 8'hE7, tx_b1, 1, 0, "R4");        // short strobe
        idle(2);
        chk("R4", "strobe_err", strobe_err, 1);
        chk("R4", "b1 data kept", rx_b1_data, 8'h33);
        slot(1, 8, 8'h55, tx_b1, 1, 1, "R10");
        idle(2);
        chk("R10", "strobe_err sticky", strobe_err, 1);

        do_reset();
        chk("R10", "strobe_err cleared by reset", strobe_err, 0);
        slot(2, 8, 8'h66, tx_b2, 1, 1, "R5");
        idle(1);
        slot(1, 10, 8'h77, tx_b1, 1, 1, "R5");      // long strobe
        idle(2);
        chk("R5", "strobe_err", strobe_err, 1);

        do_reset();
        hb = 3900;                                   // about 128 kHz
        slot(2, 8, 8'hA9, tx_b2, 1, 1, "R9");
        idle(1);
        slot(1, 8, 8'h5B, tx_b1, 1, 1, "R9");
        idle(1);
        chk("R9", "no error at low rate", strobe_err, 0);
        hb = 140;

        chk("R2", "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule